// File: doc/BRIEF.md
# Serial ADC Host Read Controller

This block is the host side of a three-wire link to a 10-bit successive-approximation converter. The converter starts sampling when its select line falls. It holds its data line low while it converts, and raises the line when the result is ready. The controller drives the select line and the serial clock, and it reads the data line. On a start pulse it selects the converter with the clock parked low. It then waits until it sees the data line rise or until a conversion timeout expires. After that it clocks the frame in with the clock idling low, sampling on rising edges. The frame is a leading 1, ten result bits with the MSB first, two sub-bits, and then zeros.

Two read lengths are offered. A short read of 11 clocks takes the leading bit and the ten result bits. A long read of 16 clocks fills two bytes and also returns the sub-bits. Every interval is a parameter counted in system clock cycles: the half period of the serial clock, the conversion timeout, the minimum deselect time between frames, the re-acquisition wait after an abort, and the two power-up delays (internal reference or external reference). If the first sample of a frame is 0, the result is still delivered and a frame-error flag is raised.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset, `busy` is high, `adc_sel_n_o` is high and `adc_sck_o` is low for PWR_INT_CYC cycles when `use_int_ref`=1, or for PWR_EXT_CYC cycles when it is 0. Start pulses arriving in this time have no effect.
- R2: A start pulse seen on a clock edge while idle drives `adc_sel_n_o` low on that edge and latches `mode_byte`. `adc_sck_o` stays low for as long as the controller waits for the end of conversion, and `adc_sel_n_o` is low only while `busy` is high.
- R3: A 0-to-1 change on `adc_sdo_i` during the wait starts the clocking phase on the third rising system clock edge after the change. The delay comes from a two-stage synchronizer followed by an edge detector.
- R4: If no rising edge is seen, the clocking phase starts CONV_CYC edges after `adc_sel_n_o` fell.
- R5: Each serial clock period is a low half of SCLK_HALF cycles followed by a high half of SCLK_HALF cycles. The data line is sampled when the clock is driven high.
- R6: With `mode_byte`=0 there are 11 serial clocks. `res_data` holds samples 2 to 11 with the MSB first, `res_sub` is 00, and `adc_sel_n_o` rises on the edge that ends the 11th high half.
- R7: With `mode_byte`=1 there are 16 serial clocks. `res_data` holds samples 2 to 11, `res_sub[1]` holds sample 12 and `res_sub[0]` holds sample 13. Samples 14 to 16 are discarded, and `adc_sel_n_o` rises after the 16th high half.
- R8: `res_valid` is a single-cycle pulse on the same edge that raises `adc_sel_n_o` at the end of a frame. On that edge `frame_err` is set to 1 exactly when the first sample of the frame was 0.
- R9: After a frame, `adc_sel_n_o` and `busy` both stay high for CSH_CYC cycles, and start pulses in that time are ignored.
- R10: An `abort` seen while `adc_sel_n_o` is low raises `adc_sel_n_o` and lowers `adc_sck_o` on that edge. No `res_valid` is produced, and `busy` stays high for ACQ_CYC further cycles.
- R11: Start pulses that arrive while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| use_int_ref | input | 1 | Selects the power-up delay: 1 for internal reference, 0 for external |
| mode_byte | input | 1 | Read length: 0 for 11 clocks, 1 for 16 clocks |
| start | input | 1 | Request one conversion |
| abort | input | 1 | End the current conversion or read early |
| adc_sdo_i | input | 1 | Serial data from the converter |
| adc_sel_n_o | output | 1 | Converter select, active low |
| adc_sck_o | output | 1 | Serial clock to the converter, idles low |
| busy | output | 1 | High whenever a start would be ignored |
| res_valid | output | 1 | One-cycle strobe marking a new result |
| res_data | output | 10 | Conversion result |
| res_sub | output | 2 | Sub-bits (long read only, 0 otherwise) |
| frame_err | output | 1 | Leading bit of the last frame was 0 |

## Verification
If the sequencer leaves a state at the wrong time, the select or clock edge lands on a different cycle from the reference timeline. This shows on the same cycle as the error, because the bench compares every output on every clock. A shift register that is wrong or misaligned stays hidden until the strobe, and then shows as a wrong result or sub-bit pattern. Frames with an all-ones value, an all-zero value and alternating patterns make any slip of one bit visible. A wrong synchronizer depth or timeout count moves the first serial clock by at least one cycle, and the frame where the timeout and the edge nearly coincide separates the two start paths.

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl #(
  parameter int SCLK_HALF   = 10,
  parameter int CONV_CYC    = 375,
  parameter int CSH_CYC     = 12,
  parameter int ACQ_CYC     = 75,
  parameter int PWR_INT_CYC = 1000000,
  parameter int PWR_EXT_CYC = 500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       use_int_ref,
  input  logic       mode_byte,
  input  logic       start,
  input  logic       abort,
  input  logic       adc_sdo_i,
  output logic       adc_sel_n_o,
  output logic       adc_sck_o,
  output logic       busy,
  output logic       res_valid,
  output logic [9:0] res_data,
  output logic [1:0] res_sub,
  output logic       frame_err
);
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int TMAX = imax(imax(imax(PWR_INT_CYC, PWR_EXT_CYC), imax(CONV_CYC, ACQ_CYC)),
                             imax(CSH_CYC, SCLK_HALF));
  localparam int TW = $clog2(TMAX + 1);
  localparam int NB_SHORT = 11;
  localparam int NB_LONG  = 16;
  localparam int NW = $clog2(NB_LONG + 1);

  typedef enum logic [2:0] {S_PWR, S_IDLE, S_CONV, S_SHIFT, S_GAP, S_HOLD} st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [NW-1:0] nclk;
  logic [NB_LONG-1:0] sh;
  logic          byte_q;
  logic          s1, s2, s3;

  wire eoc_rise  = s2 & ~s3;
  wire half_done = (tmr == TW'(SCLK_HALF - 1));
  wire [NW-1:0] last_clk = byte_q ? NW'(NB_LONG - 1) : NW'(NB_SHORT - 1);
  wire [TW-1:0] pwr_lim  = use_int_ref ? TW'(PWR_INT_CYC - 1) : TW'(PWR_EXT_CYC - 1);

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    s1 <= adc_sdo_i;
    s2 <= s1;
    s3 <= s2;
  end

  always_ff @(posedge clk) begin
    res_valid <= 1'b0;
    if (rst) begin
      st          <= S_PWR;
      tmr         <= '0;
      nclk        <= '0;
      sh          <= '0;
      byte_q      <= 1'b0;
      adc_sel_n_o <= 1'b1;
      adc_sck_o   <= 1'b0;
      res_data    <= '0;
      res_sub     <= '0;
      frame_err   <= 1'b0;
    end else begin
      case (st)
        S_PWR: begin
          if (tmr == pwr_lim) begin
            st  <= S_IDLE;
            tmr <= '0;
          end else tmr <= tmr + 1'b1;
        end
        S_IDLE: begin
          if (start) begin
            st          <= S_CONV;
            adc_sel_n_o <= 1'b0;
            byte_q      <= mode_byte;
            tmr         <= '0;
          end
        end
        S_CONV: begin
          if (abort) begin
            st          <= S_HOLD;
            adc_sel_n_o <= 1'b1;
            tmr         <= '0;
          end else if (eoc_rise || tmr == TW'(CONV_CYC - 1)) begin
            st   <= S_SHIFT;
            tmr  <= '0;
            nclk <= '0;
          end else tmr <= tmr + 1'b1;
        end
        S_SHIFT: begin
          if (abort) begin
            st          <= S_HOLD;
            adc_sel_n_o <= 1'b1;
            adc_sck_o   <= 1'b0;
            tmr         <= '0;
          end else if (half_done) begin
            tmr <= '0;
            if (!adc_sck_o) begin
              adc_sck_o <= 1'b1;
              sh        <= {sh[NB_LONG-2:0], s2};
            end else begin
              adc_sck_o <= 1'b0;
              nclk      <= nclk + 1'b1;
              if (nclk == last_clk) begin
                st          <= S_GAP;
                adc_sel_n_o <= 1'b1;
                res_valid   <= 1'b1;
                if (byte_q) begin
                  res_data  <= sh[14:5];
                  res_sub   <= sh[4:3];
                  frame_err <= ~sh[15];
                end else begin
                  res_data  <= sh[9:0];
                  res_sub   <= 2'b00;
                  frame_err <= ~sh[10];
                end
              end
            end
          end else tmr <= tmr + 1'b1;
        end
        S_GAP: begin
          if (tmr == TW'(CSH_CYC - 1)) begin
            st  <= S_IDLE;
            tmr <= '0;
          end else tmr <= tmr + 1'b1;
        end
        S_HOLD: begin
          if (tmr == TW'(ACQ_CYC - 1)) begin
            st  <= S_IDLE;
            tmr <= '0;
          end else tmr <= tmr + 1'b1;
        end
        default: st <= S_PWR;
      endcase
    end
  end
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
  parameter int SCLK_HALF = 10
) (
  input logic       clk,
  input logic       rst,
  input logic       sel_n,
  input logic       sck,
  input logic       busy,
  input logic       valid,
  input logic       byte_q,
  input logic [1:0] sub
);
  logic        sck_d;
  int unsigned hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d  <= 1'b0;
      hi_cnt <= 0;
    end else begin
      sck_d  <= sck;
      hi_cnt <= (sck && !sck_d) ? 0 : hi_cnt + 1;
    end
  end

  AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (rst) sel_n |-> !sck); // R2
  AST_SEL_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst) !sel_n |-> busy); // R2
  AST_VALID_SINGLE:       assert property (@(posedge clk) disable iff (rst) valid |=> !valid); // R8
  AST_VALID_AT_DESELECT:  assert property (@(posedge clk) disable iff (rst) valid |-> (sel_n && $past(!sel_n))); // R8
  AST_SHORT_SUB_CLEAR:    assert property (@(posedge clk) disable iff (rst) (valid && !byte_q) |-> (sub == 2'b00)); // R6
  AST_HIGH_HALF_LEN:      assert property (@(posedge clk) disable iff (rst) (!sck && sck_d && !sel_n) |-> (hi_cnt == SCLK_HALF - 1)); // R5
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(.SCLK_HALF(SCLK_HALF)) u_chk (
  .clk(clk), .rst(rst), .sel_n(adc_sel_n_o), .sck(adc_sck_o), .busy(busy),
  .valid(res_valid), .byte_q(byte_q), .sub(res_sub)
);

// File: tb/test_adc_rd_ctrl.sv
module test_adc_rd_ctrl;
  localparam int HALF = 10, CONV = 375, CSH = 12, ACQ = 75, PWI = 40, PWE = 20;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, use_int_ref = 1'b1, mode_byte = 1'b0, start = 1'b0, abort = 1'b0, sdo = 1'b0;
  logic sel_n, sck, busy, valid, ferr;
  logic [9:0] result;
  logic [1:0] sub;

  adc_rd_ctrl #(.SCLK_HALF(HALF), .CONV_CYC(CONV), .CSH_CYC(CSH), .ACQ_CYC(ACQ),
                .PWR_INT_CYC(PWI), .PWR_EXT_CYC(PWE)) i_adc_rd_ctrl (
    .clk(clk), .rst(rst), .use_int_ref(use_int_ref), .mode_byte(mode_byte), .start(start),
    .abort(abort), .adc_sdo_i(sdo), .adc_sel_n_o(sel_n), .adc_sck_o(sck), .busy(busy),
    .res_valid(valid), .res_data(result), .res_sub(sub), .frame_err(ferr));

  int vectors = 0, errors = 0;
  string cur_req = "R1";
  bit armed = 0;

  // converter model
  logic [9:0] dev_code = '0;
  logic [1:0] dev_sub = '0;
  int dev_conv = 10;
  bit dev_dead = 0, dev_eoc = 0, conv_on = 0;
  logic sel_prev = 1'b1, sck_prev = 1'b0;
  int left = 0, idx = 0;

  always @(negedge clk) begin
    if (sel_n !== 1'b0) begin
      sdo = 1'b0; conv_on = 0; dev_eoc = 0; idx = 0;
    end else if (sel_prev === 1'b1) begin
      conv_on = 1; left = dev_conv; sdo = 1'b0;
    end else if (conv_on) begin
      left--;
      if (left <= 0) begin
        conv_on = 0;
        if (!dev_dead) begin sdo = 1'b1; dev_eoc = 1; end
      end
    end else if (sck_prev === 1'b1 && sck === 1'b0) begin
      logic [15:0] fr;
      fr = {dev_code, dev_sub, 4'b0000};
      sdo = (dev_dead || idx > 15) ? 1'b0 : fr[15-idx];
      idx++;
    end
    sel_prev = sel_n;
    sck_prev = sck;
  end

  // reference timeline
  logic e_sel = 1'b1, e_sck = 1'b0, e_busy = 1'b1, e_valid = 1'b0, e_ferr = 1'b0;
  logic [9:0] e_res = '0;
  logic [1:0] e_sub = '0;

  task automatic run_frame();
    bit m = mode_byte;
    bit ab = 0, go = 0;
    int age = 0, t = 0;
    e_sel = 1'b0; e_busy = 1'b1;
    while (!go && !ab) begin
      @(posedge clk); t++;
      if (abort) ab = 1;
      else begin
        if (dev_eoc) age++;
        if (age == 3 || t == CONV) go = 1; // R3 edge path, R4 timeout path
      end
    end
    if (!ab) begin
      for (int k = 1; k <= 2 * (m ? 16 : 11) * HALF && !ab; k++) begin
        @(posedge clk);
        if (abort) ab = 1;
        else if (k % HALF == 0) e_sck = ~e_sck;
      end
    end
    if (ab) begin // R10
      e_sel = 1'b1; e_sck = 1'b0;
      repeat (ACQ) @(posedge clk);
      e_busy = 1'b0;
      return;
    end
    e_sel = 1'b1; e_valid = 1'b1;
    e_res = dev_dead ? 10'd0 : dev_code;
    e_sub = (dev_dead || !m) ? 2'b00 : dev_sub;
    e_ferr = dev_dead;
    @(posedge clk);
    e_valid = 1'b0;
    repeat (CSH - 1) @(posedge clk); // R9
    e_busy = 1'b0;
  endtask

  task automatic ref_model();
    int lim = use_int_ref ? PWI : PWE;
    repeat (lim) @(posedge clk); // R1
    e_busy = 1'b0;
    forever begin
      @(posedge clk);
      if (start) run_frame(); // R11: starts only seen while idle
    end
  endtask

  initial begin
    forever begin
      e_sel = 1'b1; e_sck = 1'b0; e_busy = 1'b1; e_valid = 1'b0;
      wait (rst == 1'b0);
      fork
        ref_model();
        @(posedge rst);
      join_any
      disable fork;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) %s: actual %0h expected %0h at %0t", tag, cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      chk("R2", 32'(sel_n), 32'(e_sel), "select");
      chk("R5", 32'(sck), 32'(e_sck), "serial clock");
      chk("R11", 32'(busy), 32'(e_busy), "busy");
      chk("R8", 32'(valid), 32'(e_valid), "valid");
      if (e_valid) begin
        chk("R6", 32'(result), 32'(e_res), "result");
        chk("R7", 32'(sub), 32'(e_sub), "sub bits");
        chk("R8", 32'(ferr), 32'(e_ferr), "frame error");
      end
    end
  end

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; vectors++;
    $display("FAIL watchdog (%s): actual running expected done", cur_req);
    finish_run();
  end

  task automatic set_dev(logic [9:0] c, logic [1:0] s, int cv, bit dead);
    @(negedge clk);
    dev_code = c; dev_sub = s; dev_conv = cv; dev_dead = dead;
  endtask

  task automatic pulse_start(bit m);
    @(negedge clk); mode_byte = m; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_abort();
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
  endtask

  task automatic hold_start(int n);
    @(negedge clk); start = 1'b1;
    repeat (n) @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    armed = 1;                 // R1 reset state compared here
    @(negedge clk); rst = 1'b0;
    repeat (5) @(negedge clk);
    hold_start(1);             // R1: ignored during power-up
    wait_idle();

    cur_req = "R6"; set_dev(10'h2A5, 2'b10, 100, 0); pulse_start(0); wait_idle();

    cur_req = "R7"; set_dev(10'h15A, 2'b01, 60, 0); pulse_start(1);
    cur_req = "R11"; repeat (20) @(negedge clk); hold_start(1);
    while (!valid) @(negedge clk);
    cur_req = "R9"; start = 1'b1; repeat (5) @(negedge clk); start = 1'b0;
    wait_idle();

    cur_req = "R4"; set_dev(10'h000, 2'b00, 1, 1); pulse_start(1); wait_idle();
    cur_req = "R4"; set_dev(10'h3FF, 2'b11, CONV - 2, 0); pulse_start(1); wait_idle();
    cur_req = "R3"; set_dev(10'h000, 2'b00, CONV - 4, 0); pulse_start(0); wait_idle();

    cur_req = "R10"; set_dev(10'h155, 2'b01, 200, 0); pulse_start(0);
    repeat (50) @(negedge clk); pulse_abort();
    hold_start(10); wait_idle();

    cur_req = "R10"; set_dev(10'h0AA, 2'b10, 30, 0); pulse_start(1);
    while (!sck) @(negedge clk);
    repeat (45) @(negedge clk); pulse_abort(); wait_idle();

    cur_req = "R6"; set_dev(10'h001, 2'b11, 10, 0); pulse_start(0); wait_idle();

    cur_req = "R1";
    @(negedge clk); armed = 0; rst = 1'b1; use_int_ref = 1'b0;
    repeat (3) @(negedge clk);
    armed = 1;
    @(negedge clk); rst = 1'b0;
    hold_start(2);
    wait_idle();

    cur_req = "R7"; set_dev(10'h0F0, 2'b10, 80, 0); pulse_start(1); wait_idle();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule